// File: doc/BRIEF.md
# Display Frame Base and Panel Power Control

This block sits on the register bus of a framebuffer display engine. Software writes a new frame base address at any moment. The block holds that address in a shadow register until the timing generator reports the first line of the next frame. At that point it copies the address into the active register that the fetch logic uses, and it raises an interrupt, so a frame is never fetched from two buffers. A base address that is not a multiple of four bytes is rejected and flagged through a second interrupt source. Two further registers enable interrupt sources and clear them, and there are read-only views of the raw and masked status. The line pitch is not programmable; the fetch side derives it from the active width and the pixel size.

The block also enforces the panel power order. The enable output must be set and must stay set for a programmable settle interval before the power output may rise. The power output must be cleared, and the same interval must pass, before the enable output may fall. The interval is a count of reference clocks, and its reset value corresponds to about 20 ms at 125 MHz. A busy bit in the control register shows that a settle interval is running.

Register offsets (word index on the 3-bit address): 0 base (write: shadow, read: active), 1 interrupt enable, 2 raw status (read), 3 masked status (read), 4 clear (write), 5 control, 6 settle count, 7 shadow base (read). Interrupt bit 0 is "base adopted" and bit 1 is "misaligned base write". Reads of offset 4 return zero.

Top module: `dispctl_regs`

## Requirements
- R1: After reset, panel_en, panel_pwr and irq are 0. The active base (offset 0), the shadow base (offset 7), raw status (offset 2) and interrupt enable (offset 1) all read 0, and wr_ready and rd_ready are 1.
- R2: A write to offset 0 with bits [1:0] equal to zero updates the shadow base (read at offset 7) and marks it pending. The active base read at offset 0 stays unchanged until it is adopted.
- R3: On a cycle with frame_start high and a pending shadow, the active base takes the shadow value at that clock edge, raw bit 0 is set and the pending mark is cleared. A frame_start with nothing pending changes neither the active base nor raw bit 0.
- R4: A write to offset 0 with bits [1:0] not equal to zero leaves the shadow base and the pending mark unchanged and sets raw bit 1.
- R5: Offset 3 reads raw status ANDed with the 2-bit enable at offset 1. Output irq is high exactly when that value is nonzero.
- R6: A write to offset 4 clears each raw bit whose data bit is 1. Bits written as 0 are left alone. If a bit is set and cleared in the same cycle, it ends up set.
- R7: In the off state, a control write (offset 5) with bit 0 = 1 sets panel_en at that edge. Control read bit 2 (busy) then stays 1 for exactly settle+1 cycles, where settle is the value at offset 6.
- R8: A control write with bits 1 and 0 both 1 raises panel_pwr at that edge only if the enable settle interval has already finished. The same write is ignored while off or while settling. Control read bits 1:0 mirror panel_pwr and panel_en.
- R9: While powered, a control write with bit 1 = 0 clears panel_pwr at that edge and starts a settle interval of settle+1 busy cycles, with panel_en kept at 1. Clearing bit 0 alone while powered is ignored.
- R10: Once enabled and unpowered with no settle running, a control write with bit 0 = 0 clears panel_en at that edge. In the off state, a write with only bit 1 set is ignored.
- R11: panel_pwr is never 1 while panel_en is 0.
- R12: When a valid base write and frame_start with a pending shadow happen in the same cycle, the active base takes the old shadow value, and the new value stays pending for the next frame_start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Register write request |
| wr_ready | output | 1 | Write accepted (always 1) |
| wr_addr | input | 3 | Register write word offset |
| wr_data | input | 32 | Register write data |
| rd_valid | input | 1 | Register read request |
| rd_ready | output | 1 | Read data valid (always 1, same cycle) |
| rd_addr | input | 3 | Register read word offset |
| rd_data | output | 32 | Read data, zero when rd_valid is low |
| frame_start | input | 1 | One-cycle pulse on the first line of a frame |
| active_base | output | 32 | Base address used by the fetch logic |
| panel_en | output | 1 | Panel enable |
| panel_pwr | output | 1 | Panel power |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that frame_start is a single-cycle pulse from the timing generator and that writes arrive with wr_valid held for exactly one cycle. They also assume that rst_n is low at time zero, so the past-value checks on the power order and base adoption see only reset state in their first cycle. The stimulus drives frame_start and every register access from negedge-aligned tasks of one cycle each. It chooses misaligned base values, enable masks and clear masks at random, and keeps control writes directed, with a short settle count programmed at offset 6, so that every settle interval is measured to the cycle.

// File: rtl/dispctl_pkg.sv
package dispctl_pkg;

  localparam int NUM_IRQ     = 2;
  localparam int IRQ_ADOPT   = 0;
  localparam int IRQ_BADBASE = 1;

  typedef enum logic [2:0] {
    REG_BASE   = 3'd0,
    REG_IEN    = 3'd1,
    REG_RAW    = 3'd2,
    REG_MASKED = 3'd3,
    REG_CLR    = 3'd4,
    REG_CTRL   = 3'd5,
    REG_SETTLE = 3'd6,
    REG_SHADOW = 3'd7
  } reg_off_e;

  typedef enum logic [2:0] {
    SEQ_OFF,
    SEQ_EN_WAIT,
    SEQ_EN_READY,
    SEQ_ON,
    SEQ_PWR_WAIT
  } seq_state_e;

  function automatic logic word_aligned(input logic [1:0] low_bits);
    return low_bits == 2'b00;
  endfunction

  function automatic logic [NUM_IRQ-1:0] irq_masked(input logic [NUM_IRQ-1:0] raw,
                                                    input logic [NUM_IRQ-1:0] ena);
    return raw & ena;
  endfunction

  function automatic logic [NUM_IRQ-1:0] irq_next(input logic [NUM_IRQ-1:0] raw,
                                                  input logic [NUM_IRQ-1:0] clr,
                                                  input logic [NUM_IRQ-1:0] set);
    return (raw & ~clr) | set;
  endfunction

endpackage

// File: rtl/dispctl_base_shadow.sv
module dispctl_base_shadow #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          base_wr,
  input  logic [DW-1:0] base_data,
  input  logic          frame_start,
  output logic [DW-1:0] active_q,
  output logic [DW-1:0] shadow_q,
  output logic          adopt,
  output logic          bad_wr
);
  import dispctl_pkg::*;

  logic pending_q;
  logic good_wr;

  assign good_wr = base_wr & word_aligned(base_data[1:0]);
  assign bad_wr  = base_wr & ~word_aligned(base_data[1:0]);
  assign adopt   = frame_start & pending_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q  <= '0;
      shadow_q  <= '0;
      pending_q <= 1'b0;
    end else begin
      if (adopt) active_q <= shadow_q;
      if (good_wr) begin
        shadow_q  <= base_data;
        pending_q <= 1'b1;
      end else if (adopt) begin
        pending_q <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/dispctl_irq.sv
module dispctl_irq #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_evt,
  input  logic         ien_wr,
  input  logic         clr_wr,
  input  logic [N-1:0] wdata,
  output logic [N-1:0] raw_q,
  output logic [N-1:0] ien_q,
  output logic [N-1:0] masked,
  output logic         irq
);
  import dispctl_pkg::*;

  logic [N-1:0] clr_mask;

  assign clr_mask = clr_wr ? wdata : '0;
  assign masked   = irq_masked(raw_q, ien_q);
  assign irq      = |masked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q <= '0;
      ien_q <= '0;
    end else begin
      raw_q <= irq_next(raw_q, clr_mask, set_evt);
      if (ien_wr) ien_q <= wdata;
    end
  end

endmodule

// File: rtl/dispctl_panel_seq.sv
module dispctl_panel_seq #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_wr,
  input  logic             want_en,
  input  logic             want_pwr,
  input  logic [CNT_W-1:0] settle,
  output logic             panel_en,
  output logic             panel_pwr,
  output logic             busy
);
  import dispctl_pkg::*;

  seq_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             cnt_done;

  assign cnt_done  = (cnt_q == '0);
  assign panel_en  = (state_q != SEQ_OFF);
  assign panel_pwr = (state_q == SEQ_ON);
  assign busy      = (state_q == SEQ_EN_WAIT) || (state_q == SEQ_PWR_WAIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_OFF;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        SEQ_OFF: if (ctrl_wr && want_en) begin
          state_q <= SEQ_EN_WAIT;
          cnt_q   <= settle;
        end
        SEQ_EN_WAIT, SEQ_PWR_WAIT: begin
          if (cnt_done) state_q <= SEQ_EN_READY;
          else          cnt_q   <= cnt_q - 1'b1;
        end
        SEQ_EN_READY: if (ctrl_wr) begin
          if (!want_en)      state_q <= SEQ_OFF;
          else if (want_pwr) state_q <= SEQ_ON;
        end
        SEQ_ON: if (ctrl_wr && !want_pwr) begin
          state_q <= SEQ_PWR_WAIT;
          cnt_q   <= settle;
        end
        default: state_q <= SEQ_OFF;
      endcase
    end
  end

endmodule

// File: rtl/dispctl_regs.sv
module dispctl_regs #(
  parameter int DW         = 32,
  parameter int CNT_W      = 24,
  parameter int DEF_SETTLE = 2500000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [2:0]    wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_valid,
  output logic          rd_ready,
  input  logic [2:0]    rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic          frame_start,
  output logic [DW-1:0] active_base,
  output logic          panel_en,
  output logic          panel_pwr,
  output logic          irq
);
  import dispctl_pkg::*;

  localparam int PAD_IRQ = DW - NUM_IRQ;
  localparam int PAD_CNT = DW - CNT_W;

  logic                 wr_base, wr_ien, wr_clr, wr_ctrl, wr_settle;
  logic [DW-1:0]        shadow_base;
  logic                 base_adopt, base_bad;
  logic [NUM_IRQ-1:0]   irq_set, irq_raw, irq_en, irq_mask;
  logic [CNT_W-1:0]     settle_q;
  logic                 seq_busy;

  assign wr_ready  = 1'b1;
  assign rd_ready  = 1'b1;
  assign wr_base   = wr_valid && (wr_addr == REG_BASE);
  assign wr_ien    = wr_valid && (wr_addr == REG_IEN);
  assign wr_clr    = wr_valid && (wr_addr == REG_CLR);
  assign wr_ctrl   = wr_valid && (wr_addr == REG_CTRL);
  assign wr_settle = wr_valid && (wr_addr == REG_SETTLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         settle_q <= CNT_W'(DEF_SETTLE);
    else if (wr_settle) settle_q <= wr_data[CNT_W-1:0];
  end

  dispctl_base_shadow #(.DW(DW)) u_base (
    .clk(clk), .rst_n(rst_n),
    .base_wr(wr_base), .base_data(wr_data), .frame_start(frame_start),
    .active_q(active_base), .shadow_q(shadow_base),
    .adopt(base_adopt), .bad_wr(base_bad)
  );

  always_comb begin
    irq_set              = '0;
    irq_set[IRQ_ADOPT]   = base_adopt;
    irq_set[IRQ_BADBASE] = base_bad;
  end

  dispctl_irq #(.N(NUM_IRQ)) u_irq (
    .clk(clk), .rst_n(rst_n),
    .set_evt(irq_set), .ien_wr(wr_ien), .clr_wr(wr_clr),
    .wdata(wr_data[NUM_IRQ-1:0]),
    .raw_q(irq_raw), .ien_q(irq_en), .masked(irq_mask), .irq(irq)
  );

  dispctl_panel_seq #(.CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .ctrl_wr(wr_ctrl), .want_en(wr_data[0]), .want_pwr(wr_data[1]),
    .settle(settle_q),
    .panel_en(panel_en), .panel_pwr(panel_pwr), .busy(seq_busy)
  );

  always_comb begin
    rd_data = '0;
    if (rd_valid) begin
      case (rd_addr)
        REG_BASE:   rd_data = active_base;
        REG_IEN:    rd_data = {{PAD_IRQ{1'b0}}, irq_en};
        REG_RAW:    rd_data = {{PAD_IRQ{1'b0}}, irq_raw};
        REG_MASKED: rd_data = {{PAD_IRQ{1'b0}}, irq_mask};
        REG_CTRL:   rd_data = {{(DW-3){1'b0}}, seq_busy, panel_pwr, panel_en};
        REG_SETTLE: rd_data = {{PAD_CNT{1'b0}}, settle_q};
        REG_SHADOW: rd_data = shadow_base;
        default:    rd_data = '0;
      endcase
    end
  end

endmodule

// File: rtl/dispctl_regs_chk.sv
module dispctl_regs_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          frame_start,
  input logic          panel_en,
  input logic          panel_pwr,
  input logic          irq,
  input logic          base_adopt,
  input logic          base_bad,
  input logic [DW-1:0] active_base,
  input logic [DW-1:0] shadow_base,
  input logic [1:0]    irq_raw
);

  AST_PWR_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    panel_pwr |-> panel_en); // R11

  AST_EN_FALL_UNPOWERED: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(panel_en) |-> !$past(panel_pwr)); // R10

  AST_PWR_RISE_AFTER_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(panel_pwr) |-> $past(panel_en)); // R8

  AST_ADOPT_AT_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    base_adopt |-> frame_start); // R3

  AST_ADOPT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    base_adopt |=> irq_raw[0]); // R3

  AST_ADOPT_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    base_adopt |=> (active_base == $past(shadow_base))); // R3

  AST_ACTIVE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !base_adopt |=> $stable(active_base)); // R2

  AST_BAD_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    base_bad |=> (irq_raw[1] && $stable(shadow_base))); // R4

  AST_IRQ_NEEDS_RAW: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (irq_raw != 2'b00)); // R5

endmodule

bind dispctl_regs dispctl_regs_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
  .panel_en(panel_en), .panel_pwr(panel_pwr), .irq(irq),
  .base_adopt(base_adopt), .base_bad(base_bad),
  .active_base(active_base), .shadow_base(shadow_base),
  .irq_raw(irq_raw)
);

// File: tb/dispctl_regs_test.sv
module dispctl_regs_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0, rd_valid = 1'b0, frame_start = 1'b0;
  logic [2:0]  wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  logic        wr_ready, rd_ready, panel_en, panel_pwr, irq;
  logic [31:0] rd_data, active_base;

  int vectors = 0;
  int miscompares = 0;

  logic [31:0] m_active = 0, m_shadow = 0;
  logic        m_pending = 0;
  logic [1:0]  m_raw = 0, m_en = 0;
  logic [31:0] v;

  always #4 clk = ~clk;

  dispctl_regs uut (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr), .rd_data(rd_data),
    .frame_start(frame_start), .active_base(active_base),
    .panel_en(panel_en), .panel_pwr(panel_pwr), .irq(irq)
  );

  function automatic logic [1:0] exp_masked(input logic [1:0] r, input logic [1:0] e);
    logic [1:0] o;
    for (int i = 0; i < 2; i++) o[i] = r[i] ? e[i] : 1'b0;
    return o;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_valid = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    rd_valid = 1'b1; rd_addr = a;
    #1 d = rd_data;
    rd_valid = 1'b0;
  endtask

  task automatic frame();
    @(negedge clk);
    frame_start = 1'b1;
    @(posedge clk); #1;
    frame_start = 1'b0;
  endtask

  task automatic count_busy(output int n);
    logic [31:0] c;
    n = 0;
    rd(3'd5, c);
    while (c[2] && n < 1000) begin
      n++;
      @(posedge clk); #1;
      rd(3'd5, c);
    end
  endtask

  task automatic check_irq_state(input string tag);
    logic [31:0] d;
    rd(3'd2, d); check({"R6 raw ", tag}, d, {30'd0, m_raw});
    rd(3'd3, d); check({"R5 masked ", tag}, d, {30'd0, exp_masked(m_raw, m_en)});
    check({"R5 irq ", tag}, {31'd0, irq}, {31'd0, exp_masked(m_raw, m_en) != 2'b00});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    int n;
    logic [31:0] d;
    void'($urandom(32'd7741));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;

    // R1 reset state
    check("R1 panel_en", {31'd0, panel_en}, 32'd0);
    check("R1 panel_pwr", {31'd0, panel_pwr}, 32'd0);
    check("R1 irq", {31'd0, irq}, 32'd0);
    check("R1 ready", {30'd0, wr_ready, rd_ready}, 32'd3);
    rd(3'd0, d); check("R1 active", d, 32'd0);
    rd(3'd7, d); check("R1 shadow", d, 32'd0);
    rd(3'd2, d); check("R1 raw", d, 32'd0);
    rd(3'd1, d); check("R1 ien", d, 32'd0);

    // R3 frame with nothing pending
    frame();
    rd(3'd0, d); check("R3 idle frame active", d, 32'd0);
    rd(3'd2, d); check("R3 idle frame raw", d, 32'd0);

    // R2..R6 random mix
    for (int it = 0; it < 300; it++) begin
      int op;
      op = $urandom % 5;
      case (op)
        0: begin
          v = $urandom;
          if (($urandom % 4) != 0) v[1:0] = 2'b00;
          wr(3'd0, v);
          if (v[1:0] == 2'b00) begin m_shadow = v; m_pending = 1'b1; end
          else m_raw[1] = 1'b1;
          rd(3'd7, d); check("R2/R4 shadow", d, m_shadow);
          rd(3'd0, d); check("R2 active held", d, m_active);
        end
        1: begin
          frame();
          if (m_pending) begin m_active = m_shadow; m_pending = 1'b0; m_raw[0] = 1'b1; end
          rd(3'd0, d); check("R3 active", d, m_active);
          check("R3 port", active_base, m_active);
        end
        2: begin
          v = $urandom;
          wr(3'd1, v);
          m_en = v[1:0];
        end
        3: begin
          v = $urandom;
          wr(3'd4, v);
          m_raw = m_raw & ~v[1:0];
        end
        default: @(posedge clk);
      endcase
      #1 check_irq_state("rand");
    end

    // R6 set and clear in the same cycle: set wins
    wr(3'd4, 32'h3); m_raw = 2'b00;
    wr(3'd0, 32'h1000_0000); m_shadow = 32'h1000_0000; m_pending = 1'b1;
    @(negedge clk);
    frame_start = 1'b1; wr_valid = 1'b1; wr_addr = 3'd4; wr_data = 32'h1;
    @(posedge clk); #1;
    frame_start = 1'b0; wr_valid = 1'b0;
    m_active = m_shadow; m_pending = 1'b0; m_raw[0] = 1'b1;
    rd(3'd2, d); check("R6 set wins over clear", d, {30'd0, m_raw});

    // R12 write and adopt in one cycle
    wr(3'd0, 32'h2000_0000);
    @(negedge clk);
    frame_start = 1'b1; wr_valid = 1'b1; wr_addr = 3'd0; wr_data = 32'h3000_0000;
    @(posedge clk); #1;
    frame_start = 1'b0; wr_valid = 1'b0;
    rd(3'd0, d); check("R12 old shadow adopted", d, 32'h2000_0000);
    rd(3'd7, d); check("R12 new shadow kept", d, 32'h3000_0000);
    frame();
    rd(3'd0, d); check("R12 new shadow adopted later", d, 32'h3000_0000);

    // R7 power-up settle
    wr(3'd6, 32'd5);
    wr(3'd5, 32'h2);
    check("R10 pwr-only write from off ignored", {30'd0, panel_pwr, panel_en}, 32'd0);
    wr(3'd5, 32'h3);
    check("R7 enable set, pwr held", {30'd0, panel_pwr, panel_en}, 32'd1);
    count_busy(n);
    check("R7 busy cycles", n, 32'd6);
    // R10 disable from enabled-unpowered
    wr(3'd5, 32'h0);
    check("R10 enable cleared", {30'd0, panel_pwr, panel_en}, 32'd0);

    // R8 pwr request during settle ignored
    wr(3'd5, 32'h1);
    wr(3'd5, 32'h3);
    check("R8 pwr ignored while settling", {30'd0, panel_pwr, panel_en}, 32'd1);
    count_busy(n);
    check("R8 still unpowered after settle", {30'd0, panel_pwr, panel_en}, 32'd1);
    wr(3'd5, 32'h3);
    check("R8 powered", {30'd0, panel_pwr, panel_en}, 32'd3);
    rd(3'd5, d); check("R8 ctrl readback", d, 32'd3);

    // R9 clearing enable alone while powered is ignored
    wr(3'd5, 32'h2);
    check("R9 en clear ignored while powered", {30'd0, panel_pwr, panel_en}, 32'd3);
    wr(3'd5, 32'h1);
    check("R9 power dropped, enable kept", {30'd0, panel_pwr, panel_en}, 32'd1);
    count_busy(n);
    check("R9 power-down busy cycles", n, 32'd6);
    check("R9 enable after settle", {30'd0, panel_pwr, panel_en}, 32'd1);
    wr(3'd5, 32'h0);
    check("R10 final disable", {30'd0, panel_pwr, panel_en}, 32'd0);
    check("R11 pwr implies en", {31'd0, panel_pwr & ~panel_en}, 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule